// File: doc/BRIEF.md
# Registered Half-to-Full Bus Exchanger

This block joins a narrow port of `HALF_W` bits (12 by default) with a wide port of twice that width. The wide port is treated as a low half and a high half.

Going narrow to wide, two narrow words arrive on consecutive cycles. Each is written into its own half of a wide holding register under a separate active-low load enable. Once both halves are filled, the register shows the pair as one wide word. Going wide to narrow, a single wide register takes in the wide input on every rising clock edge. A half-select line then picks which half of that stored word drives the narrow output.

Each side has an active-low output enable. The enable produces a drive-enable signal next to the data, so a pad ring or bus fabric can build three-state drivers from the two signals.

Top module: `bus_exchanger`

## Requirements
- R1: While `rst` is high at a rising edge, both halves of the wide holding register and the wide-to-narrow register clear to zero, so `b_out` and `a_out` read 0 afterwards.
- R2: At a rising edge with `ld_lo_n` low, bits [HALF_W-1:0] of `b_out` take the value of `a_in`.
- R3: At a rising edge with `ld_hi_n` low, bits [2*HALF_W-1:HALF_W] of `b_out` take the value of `a_in`.
- R4: With both load enables low at the same edge, both halves take the same `a_in` word.
- R5: With both load enables high at an edge, `b_out` holds its value.
- R6: The wide-to-narrow register captures all of `b_in` on every rising edge. A change on `b_in` between edges does not reach `a_out` before the next edge.
- R7: `sel_hi` = 0 routes the low half of the stored wide word to `a_out`, and `sel_hi` = 1 routes the high half. A change of `sel_hi` shows on `a_out` with no clock edge.
- R8: `a_drv` is 1 exactly when `oe_a_n` is 0, independent of `oe_b_n`.
- R9: `b_drv` is 1 exactly when `oe_b_n` is 0, independent of `oe_a_n`.
- R10: The output enables have no effect on the stored data. `b_out` and `a_out` keep their values while the enables toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_lo_n | input | 1 | Active-low load enable for the low wide half |
| ld_hi_n | input | 1 | Active-low load enable for the high wide half |
| sel_hi | input | 1 | Chooses the stored half for the narrow output (1 = high) |
| oe_a_n | input | 1 | Active-low output enable, narrow side |
| oe_b_n | input | 1 | Active-low output enable, wide side |
| a_in | input | HALF_W | Narrow input word |
| b_in | input | 2*HALF_W | Wide input word |
| a_out | output | HALF_W | Narrow output data |
| a_drv | output | 1 | Narrow output drive enable |
| b_out | output | 2*HALF_W | Wide output data |
| b_drv | output | 1 | Wide output drive enable |

## Verification
Loads and captures on both paths take effect one edge after their inputs are applied. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. The half select and both output enables are combinational paths. For these, the bench changes the input between edges and samples 1 ns later, with no edge in between. For R6, the bench also reads `a_out` before the capturing edge, to confirm the register has not passed a new `b_in` through early.

// File: rtl/bus_exchanger.sv
module bus_exchanger #(
  parameter int HALF_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_lo_n,
  input  logic                ld_hi_n,
  input  logic                sel_hi,
  input  logic                oe_a_n,
  input  logic                oe_b_n,
  input  logic [HALF_W-1:0]   a_in,
  input  logic [2*HALF_W-1:0] b_in,
  output logic [HALF_W-1:0]   a_out,
  output logic                a_drv,
  output logic [2*HALF_W-1:0] b_out,
  output logic                b_drv
);
  logic [HALF_W-1:0]   lo_q, hi_q;
  logic [2*HALF_W-1:0] ba_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
      ba_q <= '0;
    end else begin
      if (!ld_lo_n) lo_q <= a_in;
      if (!ld_hi_n) hi_q <= a_in;
      ba_q <= b_in;
    end
  end

  assign b_out = {hi_q, lo_q};
  assign a_out = sel_hi ? ba_q[2*HALF_W-1:HALF_W] : ba_q[HALF_W-1:0];
  assign a_drv = ~oe_a_n;
  assign b_drv = ~oe_b_n;
endmodule

module bus_exchanger_chk #(
  parameter int HALF_W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                ld_lo_n,
  input logic                ld_hi_n,
  input logic                sel_hi,
  input logic [HALF_W-1:0]   a_in,
  input logic [2*HALF_W-1:0] b_in,
  input logic [HALF_W-1:0]   a_out,
  input logic [2*HALF_W-1:0] b_out
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (b_out == '0));

  assert_low_load_R2: assert property (@(posedge clk) disable iff (rst)
    !ld_lo_n |=> (b_out[HALF_W-1:0] == $past(a_in)));

  assert_high_load_R3: assert property (@(posedge clk) disable iff (rst)
    !ld_hi_n |=> (b_out[2*HALF_W-1:HALF_W] == $past(a_in)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (ld_lo_n && ld_hi_n) |=> $stable(b_out));

  assert_narrow_path_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (a_out == (sel_hi ? $past(b_in[2*HALF_W-1:HALF_W])
                               : $past(b_in[HALF_W-1:0]))));
endmodule

bind bus_exchanger bus_exchanger_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst(rst), .ld_lo_n(ld_lo_n), .ld_hi_n(ld_hi_n),
  .sel_hi(sel_hi), .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out)
);

// File: tb/test_bus_exchanger.sv
module test_bus_exchanger;
  localparam int W = 12;
  localparam int N = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic ld_lo_n = 1'b1, ld_hi_n = 1'b1, sel_hi = 1'b0;
  logic oe_a_n = 1'b1, oe_b_n = 1'b1;
  logic [W-1:0] a_in = '0;
  logic [2*W-1:0] b_in = '0;
  logic [W-1:0] a_out;
  logic a_drv, b_drv;
  logic [2*W-1:0] b_out;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  bus_exchanger #(.HALF_W(W)) i_bus_exchanger (
    .clk(clk), .rst(rst), .ld_lo_n(ld_lo_n), .ld_hi_n(ld_hi_n),
    .sel_hi(sel_hi), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_drv(a_drv),
    .b_out(b_out), .b_drv(b_drv)
  );

  localparam logic        V_LO  [N] = '{0, 1, 1, 0, 0, 1, 1, 0};
  localparam logic        V_HI  [N] = '{1, 0, 1, 0, 1, 0, 1, 1};
  localparam logic        V_SEL [N] = '{0, 1, 0, 1, 1, 0, 1, 0};
  localparam logic [11:0] V_A   [N] = '{12'hABC, 12'hDEF, 12'h111, 12'h5A5,
                                        12'h777, 12'hFFF, 12'h000, 12'h000};
  localparam logic [23:0] V_B   [N] = '{24'h123456, 24'hFEDCBA, 24'h0F0F0F, 24'hC3C3C3,
                                        24'h800001, 24'h000FFF, 24'hABCDEF, 24'h000000};
  localparam logic [23:0] E_B   [N] = '{24'h000ABC, 24'hDEFABC, 24'hDEFABC, 24'h5A55A5,
                                        24'h5A5777, 24'hFFF777, 24'hFFF777, 24'hFFF000};
  localparam logic [11:0] E_A   [N] = '{12'h456, 12'hFED, 12'hF0F, 12'hC3C,
                                        12'h800, 12'hFFF, 12'hABC, 12'h000};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step();
    step();
    chk("R1 reset b_out", 32'(b_out), 32'h0);
    chk("R1 reset a_out", 32'(a_out), 32'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      ld_lo_n = V_LO[i]; ld_hi_n = V_HI[i]; sel_hi = V_SEL[i];
      a_in = V_A[i]; b_in = V_B[i];
      step();
      if (!V_LO[i] && !V_HI[i])  chk("R4 both halves", 32'(b_out), 32'(E_B[i]));
      else if (!V_LO[i])         chk("R2 low half", 32'(b_out), 32'(E_B[i]));
      else if (!V_HI[i])         chk("R3 high half", 32'(b_out), 32'(E_B[i]));
      else                       chk("R5 hold", 32'(b_out), 32'(E_B[i]));
      chk("R6 narrow capture", 32'(a_out), 32'(E_A[i]));
    end

    // R7: select acts with no clock edge
    @(negedge clk);
    ld_lo_n = 1'b1; ld_hi_n = 1'b1; b_in = 24'h123ABC; sel_hi = 1'b0;
    step();
    chk("R7 sel low", 32'(a_out), 32'hABC);
    sel_hi = 1'b1;
    #1;
    chk("R7 sel high no edge", 32'(a_out), 32'h123);

    // R6: new b_in must not pass before an edge
    @(negedge clk);
    b_in = 24'h999888;
    #1;
    chk("R6 no early pass", 32'(a_out), 32'h123);
    step();
    chk("R6 after edge", 32'(a_out), 32'h999);

    // R8, R9, R10: enables independent and without effect on data
    @(negedge clk);
    oe_a_n = 1'b0; oe_b_n = 1'b1;
    #1;
    chk("R8 a_drv on", 32'(a_drv), 32'h1);
    chk("R9 b_drv off", 32'(b_drv), 32'h0);
    oe_a_n = 1'b1; oe_b_n = 1'b0;
    #1;
    chk("R8 a_drv off", 32'(a_drv), 32'h0);
    chk("R9 b_drv on", 32'(b_drv), 32'h1);
    oe_a_n = 1'b0;
    step();
    chk("R8 both on", 32'(a_drv), 32'h1);
    chk("R10 b_out kept", 32'(b_out), 32'hFFF000);
    chk("R10 a_out kept", 32'(a_out), 32'h999);

    // R1: reset in mid run
    @(negedge clk);
    rst = 1'b1;
    step();
    chk("R1 mid reset b_out", 32'(b_out), 32'h0);
    chk("R1 mid reset a_out", 32'(a_out), 32'h0);
    @(negedge clk);
    rst = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule